// File: doc/BRIEF.md
# Image Sensor Row Select Sequencer

The sequencer selects pixel rows one at a time for readout. A start-row register is loaded through a small synchronous write port. A row clock and a row sync level arrive as plain inputs and are sampled in the block's own clock domain. A row-clock rising edge with sync high selects the programmed start row. That first row stays selected for as long as sync remains high on later row-clock edges, so its length can be stretched. Every row after it lasts exactly one row-clock period. Stepping past the last row ends the scan, and the block then waits for the next sync.

The current selection is given both as a binary row index and as a one-hot row-select vector, together with a valid flag. A one-cycle step pulse marks every clock in which a new row became selected. The block has no data stream, so there is no valid/ready handshake and no back-pressure: all pins are plain control and status signals. The row clock is expected to stay at each level for at least one system clock.

Top module: `row_select_seq`

## Requirements
- R1: After reset, sel_valid is 0, sel_step is 0, sel_onehot is all zero and the start-row register holds 0.
- R2: A row-clock rising edge with row_sync high, when the previous row-clock edge did not already start a held first row, selects the start-row register value. sel_row and sel_valid=1 show it, and sel_step pulses, in the system clock cycle after the edge is sampled.
- R3: Further row-clock rising edges with row_sync still high keep the same row selected and raise no step pulse, even if the start register is rewritten meanwhile.
- R4: A row-clock rising edge with row_sync low, while a row below the last one is selected, selects the next row (index + 1) and pulses sel_step.
- R5: sel_step is high for exactly one system clock per row change. sel_row and sel_valid change only on a sampled row-clock rising edge, never on falling edges or while the row clock stays at one level.
- R6: A row-clock rising edge with row_sync low while the last row (ROWS-1) is selected clears sel_valid without a step pulse and leaves sel_row at the last row. Later edges with row_sync low keep sel_valid at 0 until the next sync.
- R7: start_wr_en=1 on a clock edge loads start_wr_row into the start-row register. With start_wr_en=0 the register keeps its value. A value written before the sync edge is the row selected by that edge.
- R8: sel_onehot has bit sel_row set and all other bits clear while sel_valid is 1, and is all zero while sel_valid is 0.
- R9: A sync edge during an ongoing scan, when the previous edge had no sync, restarts selection at the start row with a step pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_wr_en | input | 1 | Write enable of the start-row register |
| start_wr_row | input | ROW_W | Start-row value to write |
| row_clk | input | 1 | Row clock level, sampled on clk |
| row_sync | input | 1 | Row sync level, sampled at row-clock rising edges |
| sel_valid | output | 1 | A row is currently selected |
| sel_row | output | ROW_W | Index of the selected row |
| sel_onehot | output | ROWS | One-hot row-select vector |
| sel_step | output | 1 | One-cycle pulse when a new row becomes selected |

## Verification
The bench sweeps every start row of a 16-row configuration with first-row sync lengths of one, two and three row-clock edges. It then runs each scan past the end, which separates a correct hold count from an early or late advance and shows where the scan ends for every start position. A final pattern writes the start register with the enable low, rewrites it during a held first row, and syncs again in mid-scan. This shows which write takes effect and when, and separates a restart from a hold. Every sample also compares the one-hot vector with the index and valid flag, and checks that the step pulse is gone by the row clock's low phase.

// File: rtl/rowseq_pkg.sv
package rowseq_pkg;

  // Scan phase of the row selector
  typedef enum logic [1:0] {
    SCAN_IDLE  = 2'd0,  // nothing selected since reset
    SCAN_FIRST = 2'd1,  // start row selected, sync may still be held
    SCAN_RUN   = 2'd2,  // stepping through rows one per row clock
    SCAN_DONE  = 2'd3   // stepped past the last row
  } scan_phase_e;

  function automatic logic phase_selects(input scan_phase_e ph);
    return (ph == SCAN_FIRST) || (ph == SCAN_RUN);
  endfunction

endpackage

// File: rtl/rowseq_edge_det.sv
module rowseq_edge_det (
  input  logic clk,
  input  logic rst_n,
  input  logic level_in,
  output logic rise
);

  logic level_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) level_q <= 1'b0;
    else        level_q <= level_in;
  end

  assign rise = level_in & ~level_q;

  // a rising edge can never be reported in two consecutive cycles
  a_r5_single_rise: assert property (@(posedge clk) disable iff (!rst_n)
    rise |=> !rise);

endmodule

// File: rtl/rowseq_start_reg.sv
module rowseq_start_reg #(
  parameter int ROW_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [ROW_W-1:0] wr_row,
  output logic [ROW_W-1:0] start_row
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     start_row <= '0;
    else if (wr_en) start_row <= wr_row;
  end

  a_r7_keep_without_enable: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(start_row));

  a_r7_load_with_enable: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> start_row == $past(wr_row));

endmodule

// File: rtl/rowseq_scan_ctrl.sv
module rowseq_scan_ctrl
  import rowseq_pkg::*;
#(
  parameter int ROWS  = 1024,
  parameter int ROW_W = $clog2(ROWS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             row_rise,
  input  logic             row_sync,
  input  logic [ROW_W-1:0] start_row,
  output logic [ROW_W-1:0] cur_row,
  output logic             cur_valid,
  output logic             step
);

  localparam logic [ROW_W-1:0] LAST_ROW = ROW_W'(ROWS - 1);

  scan_phase_e      phase_q, phase_d;
  logic [ROW_W-1:0] row_q, row_d;
  logic             step_d;
  logic             at_last;

  assign at_last = (row_q == LAST_ROW);

  always_comb begin
    phase_d = phase_q;
    row_d   = row_q;
    step_d  = 1'b0;
    if (row_rise) begin
      if (row_sync) begin
        // a held sync keeps the first row; a fresh sync (re)loads it
        if (phase_q != SCAN_FIRST) begin
          phase_d = SCAN_FIRST;
          row_d   = start_row;
          step_d  = 1'b1;
        end
      end else if (phase_selects(phase_q)) begin
        if (at_last) begin
          phase_d = SCAN_DONE;
        end else begin
          phase_d = SCAN_RUN;
          row_d   = row_q + 1'b1;
          step_d  = 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= SCAN_IDLE;
      row_q   <= '0;
      step    <= 1'b0;
    end else begin
      phase_q <= phase_d;
      row_q   <= row_d;
      step    <= step_d;
    end
  end

  assign cur_row   = row_q;
  assign cur_valid = phase_selects(phase_q);

  a_r2_first_row_load: assert property (@(posedge clk) disable iff (!rst_n)
    (row_rise && row_sync && phase_q != SCAN_FIRST)
      |=> (cur_valid && step && cur_row == $past(start_row)));

  a_r3_first_row_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (row_rise && row_sync && phase_q == SCAN_FIRST)
      |=> ($stable(cur_row) && cur_valid && !step));

  a_r4_advance: assert property (@(posedge clk) disable iff (!rst_n)
    (row_rise && !row_sync && cur_valid && !at_last)
      |=> (step && cur_valid && cur_row == ROW_W'($past(cur_row) + 1'b1)));

  a_r5_quiet_without_edge: assert property (@(posedge clk) disable iff (!rst_n)
    !row_rise |=> (!step && $stable(cur_row) && $stable(cur_valid)));

  a_r6_end_of_array: assert property (@(posedge clk) disable iff (!rst_n)
    (row_rise && !row_sync && cur_valid && at_last)
      |=> (!cur_valid && !step && $stable(cur_row)));

  a_r6_stay_ended: assert property (@(posedge clk) disable iff (!rst_n)
    (!cur_valid && !(row_rise && row_sync)) |=> (!cur_valid && !step));

endmodule

// File: rtl/rowseq_decoder.sv
module rowseq_decoder #(
  parameter int ROWS  = 1024,
  parameter int ROW_W = $clog2(ROWS)
) (
  input  logic             valid,
  input  logic [ROW_W-1:0] row,
  output logic [ROWS-1:0]  onehot
);

  for (genvar g = 0; g < ROWS; g++) begin : g_line
    assign onehot[g] = valid && (row == ROW_W'(g));
  end

endmodule

// File: rtl/row_select_seq.sv
module row_select_seq #(
  parameter int ROWS  = 1024,
  parameter int ROW_W = $clog2(ROWS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_wr_en,
  input  logic [ROW_W-1:0] start_wr_row,
  input  logic             row_clk,
  input  logic             row_sync,
  output logic             sel_valid,
  output logic [ROW_W-1:0] sel_row,
  output logic [ROWS-1:0]  sel_onehot,
  output logic             sel_step
);

  logic             row_rise;
  logic [ROW_W-1:0] start_row;

  rowseq_edge_det i_edge (
    .clk      (clk),
    .rst_n    (rst_n),
    .level_in (row_clk),
    .rise     (row_rise)
  );

  rowseq_start_reg #(.ROW_W(ROW_W)) i_start (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (start_wr_en),
    .wr_row    (start_wr_row),
    .start_row (start_row)
  );

  rowseq_scan_ctrl #(.ROWS(ROWS), .ROW_W(ROW_W)) i_scan (
    .clk       (clk),
    .rst_n     (rst_n),
    .row_rise  (row_rise),
    .row_sync  (row_sync),
    .start_row (start_row),
    .cur_row   (sel_row),
    .cur_valid (sel_valid),
    .step      (sel_step)
  );

  rowseq_decoder #(.ROWS(ROWS), .ROW_W(ROW_W)) i_dec (
    .valid  (sel_valid),
    .row    (sel_row),
    .onehot (sel_onehot)
  );

  a_r8_onehot_count: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(sel_onehot) == (sel_valid ? 1 : 0));

  a_r8_onehot_position: assert property (@(posedge clk) disable iff (!rst_n)
    sel_valid |-> sel_onehot[sel_row]);

  a_r5_step_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    sel_step |=> !sel_step);

endmodule

// File: tb/test_row_select_seq.sv
module test_row_select_seq;

  localparam int ROWS  = 16;
  localparam int ROW_W = 4;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             start_wr_en = 1'b0;
  logic [ROW_W-1:0] start_wr_row = '0;
  logic             row_clk = 1'b0;
  logic             row_sync = 1'b0;
  logic             sel_valid;
  logic [ROW_W-1:0] sel_row;
  logic [ROWS-1:0]  sel_onehot;
  logic             sel_step;

  int vectors = 0;
  int miscompares = 0;

  always #2 clk = ~clk;  // 250 MHz

  row_select_seq #(.ROWS(ROWS), .ROW_W(ROW_W)) i_row_select_seq (
    .clk          (clk),
    .rst_n        (rst_n),
    .start_wr_en  (start_wr_en),
    .start_wr_row (start_wr_row),
    .row_clk      (row_clk),
    .row_sync     (row_sync),
    .sel_valid    (sel_valid),
    .sel_row      (sel_row),
    .sel_onehot   (sel_onehot),
    .sel_step     (sel_step)
  );

  task automatic check(input string req, input logic ev, input int erow, input logic estep);
    logic [ROWS-1:0] eoh;
    eoh = ev ? (ROWS'(1) << erow) : '0;
    vectors++;
    if (sel_valid !== ev || sel_step !== estep || sel_onehot !== eoh ||
        (ev && sel_row !== ROW_W'(erow))) begin
      miscompares++;
      $display("FAIL %s: valid=%0b row=%0d step=%0b onehot=%h expected valid=%0b row=%0d step=%0b onehot=%h",
               req, sel_valid, sel_row, sel_step, sel_onehot, ev, erow, estep, eoh);
    end
  endtask

  task automatic check_row(input string req, input int erow);
    vectors++;
    if (sel_row !== ROW_W'(erow)) begin
      miscompares++;
      $display("FAIL %s: row=%0d expected row=%0d", req, sel_row, erow);
    end
  endtask

  task automatic write_start(input int r, input logic en);
    start_wr_row = ROW_W'(r);
    start_wr_en  = en;
    @(negedge clk);
    start_wr_en  = 1'b0;
  endtask

  // drive a row-clock rising edge; returns at the negedge after it is sampled
  task automatic edge_hi(input logic s);
    row_clk  = 1'b1;
    row_sync = s;
    @(negedge clk);
  endtask

  task automatic edge_lo();
    row_clk = 1'b0;
    @(negedge clk);
    @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    miscompares++;
    $display("FAIL R5 watchdog: cycles=200000 expected < 200000");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    @(negedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state, start register 0
    check("R1", 1'b0, 0, 1'b0);
    // R1/R6: edges without sync select nothing
    edge_hi(1'b0); check("R6", 1'b0, 0, 1'b0); edge_lo();
    // R1: start register reset value is selected by the first sync
    edge_hi(1'b1); check("R1", 1'b1, 0, 1'b1); edge_lo();
    edge_hi(1'b0); check("R4", 1'b1, 1, 1'b1); edge_lo();

    // sweep all start rows and first-row hold lengths
    for (int s = 0; s < ROWS; s++) begin
      for (int h = 1; h <= 3; h++) begin
        write_start(s, 1'b1);
        edge_hi(1'b1);
        check("R2", 1'b1, s, 1'b1);   // R7 written value used
        edge_lo();
        check("R5", 1'b1, s, 1'b0);
        for (int j = 1; j < h; j++) begin
          edge_hi(1'b1);
          check("R3", 1'b1, s, 1'b0);
          edge_lo();
        end
        for (int n = 1; n <= ROWS - s; n++) begin
          edge_hi(1'b0);
          if (s + n <= ROWS - 1) begin
            check("R4", 1'b1, s + n, 1'b1);
          end else begin
            check("R6", 1'b0, 0, 1'b0);
            check_row("R6", ROWS - 1);
          end
          edge_lo();
          check("R5", (s + n <= ROWS - 1), s + n, 1'b0);
        end
        edge_hi(1'b0);
        check("R6", 1'b0, 0, 1'b0);
        edge_lo();
      end
    end

    // R7: write with enable low is ignored
    write_start(5, 1'b1);
    write_start(9, 1'b0);
    edge_hi(1'b1); check("R7", 1'b1, 5, 1'b1); edge_lo();
    // R3/R7: rewrite during held first row does not move the selection
    write_start(9, 1'b1);
    edge_hi(1'b1); check("R3", 1'b1, 5, 1'b0); edge_lo();
    edge_hi(1'b0); check("R4", 1'b1, 6, 1'b1); edge_lo();
    edge_hi(1'b0); check("R4", 1'b1, 7, 1'b1); edge_lo();
    // R9: fresh sync mid-scan restarts at the (new) start row
    edge_hi(1'b1); check("R9", 1'b1, 9, 1'b1); edge_lo();
    check("R5", 1'b1, 9, 1'b0);
    edge_hi(1'b0); check("R9", 1'b1, 10, 1'b1);
    // R5: row clock held high for several cycles changes nothing more
    @(negedge clk); @(negedge clk);
    check("R5", 1'b1, 10, 1'b0);
    edge_lo();

    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

endmodule